// File: doc/BRIEF.md
# Full-Duplex SPI Byte Engine

This block exchanges 8-bit words over a four-wire serial link, shifting the most significant bit first and receiving while it transmits. It runs in one of two roles. As a controller it generates the serial clock itself from a programmable divider and starts a word as soon as software hands it a transmit byte while it is idle. As a peripheral it follows a clock that an external controller drives, and an active-low select frames the transfer. The incoming clock, select and data pass through a two-flop synchronizer and are edge-detected in the system clock domain.

The host side is a register-style interface with no bus decoding. It carries a transmit byte with a write strobe, a receive byte with a read strobe, a divider value and a control byte. The block returns a status byte and a single interrupt line. The control byte selects the role, the idle clock level, the sampling phase and the interrupt source. The pads are driven through separate output and output-enable signals so that the same pins can serve either role.

Top module: `spi_byte_engine`

## Requirements
- R1: Each transfer exchanges one 8-bit word in both directions at once. Bit 7 of the transmit byte is sent first, and the first bit received lands in bit 7 of `rx_data`.
- R2: As controller, each level of `sclk_o` lasts `div_val`+1 system clocks, so one serial period is 2×(`div_val`+1) clocks.
- R3: As controller, `sclk_o` rests at the level of `ctrl[1]` (polarity) before and after every word.
- R4: With `ctrl[2]`=0, bit 7 is on the data output before the first clock edge, data is sampled on the leading edge and changed on the trailing edge. With `ctrl[2]`=1, data changes on the leading edge and is sampled on the trailing edge.
- R5: With `ctrl[0]`=1 (controller), `sclk_oe` and `mosi_oe` are 1 and `miso_oe` is 0. With `ctrl[0]`=0 (peripheral), `sclk_oe` and `mosi_oe` are 0, and `miso_oe` is 1 only while the synchronized select is low.
- R6: Writing `tx_data` clears status bit 1 (transmit empty). The bit is set again when the byte moves into the shifter. As controller, a write while idle starts a word on the next cycle.
- R7: As peripheral, a falling select loads the shifter from the transmit buffer. Words then follow back to back, each reloaded from the buffer, until select rises.
- R8: As peripheral, the block receives correctly from an external clock whose levels last as little as two system clocks.
- R9: Status bit 4 (receive full) is set when a word completes and cleared by `rx_rd`. If a completion and a read fall in the same cycle, the bit stays set and `rx_data` holds the new word. All other status bits read 0, and the status after reset is 0x02.
- R10: `irq` follows status bit 4 when `ctrl[6]`=1 and status bit 1 when `ctrl[6]`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | 8 | Transmit byte |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Last received byte |
| div_val | input | 8 | Controller clock divider value |
| ctrl | input | 8 | Bit 0 role, bit 1 polarity, bit 2 phase, bit 6 interrupt source |
| status | output | 8 | Bit 1 transmit empty, bit 4 receive full |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock out (controller) |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock in (peripheral) |
| mosi_o | output | 1 | Controller data out |
| mosi_oe | output | 1 | Controller data output enable |
| mosi_i | input | 1 | Controller data in (peripheral) |
| miso_o | output | 1 | Peripheral data out |
| miso_oe | output | 1 | Peripheral data output enable |
| miso_i | input | 1 | Peripheral data in (controller) |
| cs_n_i | input | 1 | Active-low select (peripheral) |

## Verification
A word can complete in the same cycle as a host read of the receive buffer, so the set and clear of the receive-full flag collide. The bench leaves a previous word unread and times `rx_rd` to be sampled on the exact clock edge of the final serial clock toggle, which it predicts from the measured divider interval. It then requires status bit 4 to remain set and `rx_data` to show the new word, not the stale one.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   // control byte field positions
   localparam int CTL_ROLE   = 0;
   localparam int CTL_POL    = 1;
   localparam int CTL_PHASE  = 2;
   localparam int CTL_IRQSRC = 6;
   // status byte field positions
   localparam int ST_TXEMPTY = 1;
   localparam int ST_RXFULL  = 4;

   typedef struct packed {
      logic ctl_master;
      logic pol;
      logic phase;
      logic irq_on_rx;
   } spi_cfg_t;
endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
   parameter int STAGES = 2,
   parameter int W      = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_prev
);
   logic [STAGES:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
      else        pipe <= {pipe[STAGES-1:0], d};
   end

   assign q      = pipe[STAGES-1];
   assign q_prev = pipe[STAGES];
endmodule

// File: rtl/spi_eng_div.sv
module spi_eng_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = en && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!en)  cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
   import spi_eng_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   input  logic [DIV_W-1:0]  div_val,
   input  logic [7:0]        ctrl,
   output logic [7:0]        status,
   output logic              irq,
   output logic              sclk_o,
   output logic              sclk_oe,
   input  logic              sclk_i,
   output logic              mosi_o,
   output logic              mosi_oe,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe,
   input  logic              miso_i,
   input  logic              cs_n_i
);
   localparam int EDGES = 2 * DATA_W;
   localparam int CNT_W = $clog2(EDGES);
   localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_byte_engine: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_byte_engine: SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_byte_engine: DIV_W must be at least 1");
      end
   endgenerate

   spi_cfg_t cfg;
   assign cfg.ctl_master = ctrl[CTL_ROLE];
   assign cfg.pol        = ctrl[CTL_POL];
   assign cfg.phase      = ctrl[CTL_PHASE];
   assign cfg.irq_on_rx  = ctrl[CTL_IRQSRC];

   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl[7], ctrl[5:3]};

   // peripheral-side input synchronizer: {select, clock, data}
   logic [2:0] s_now, s_prev;
   spi_eng_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n_i, sclk_i, mosi_i}),
      .q(s_now), .q_prev(s_prev)
   );
   logic s_cs, s_cs_p, s_clk, s_clk_p, s_mosi;
   assign {s_cs, s_clk, s_mosi} = s_now;
   assign s_cs_p  = s_prev[2];
   assign s_clk_p = s_prev[1];

   // state
   logic              m_run, m_tgl;
   logic [CNT_W-1:0]  ecnt;
   logic [DATA_W-1:0] txbuf, sh, rxsh, rxbuf;
   logic              tx_empty, rx_full;

   logic m_tick;
   spi_eng_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(m_run), .div(div_val), .tick(m_tick)
   );

   // edge classification, shared by both roles
   logic m_edge, s_edge, any_edge, lead, samp, shft, byte_done;
   logic m_start, cs_fall, load, rx_bit;
   logic [DATA_W-1:0] rx_next;

   assign m_edge   = cfg.ctl_master && m_run && m_tick;
   assign s_edge   = !cfg.ctl_master && !s_cs && !s_cs_p && (s_clk != s_clk_p);
   assign any_edge = cfg.ctl_master ? m_edge : s_edge;
   assign lead     = cfg.ctl_master ? !ecnt[0] : (s_clk != cfg.pol);
   assign samp     = any_edge && (lead ^ cfg.phase);
   assign shft     = any_edge && !(lead ^ cfg.phase) && !(cfg.phase && ecnt == '0);
   assign byte_done = any_edge && (ecnt == LAST_EDGE);
   assign rx_bit   = cfg.ctl_master ? miso_i : s_mosi;
   assign rx_next  = samp ? {rxsh[DATA_W-2:0], rx_bit} : rxsh;

   assign m_start = cfg.ctl_master && !m_run && !tx_empty;
   assign cs_fall = !cfg.ctl_master && s_cs_p && !s_cs;
   assign load    = m_start || cs_fall || (!cfg.ctl_master && byte_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run    <= 1'b0;
         m_tgl    <= 1'b0;
         ecnt     <= '0;
         txbuf    <= '0;
         sh       <= '0;
         rxsh     <= '0;
         rxbuf    <= '0;
         tx_empty <= 1'b1;
         rx_full  <= 1'b0;
      end else begin
         if (!cfg.ctl_master)                     m_run <= 1'b0;
         else if (m_start)                        m_run <= 1'b1;
         else if (byte_done)                      m_run <= 1'b0;

         if (!m_run)      m_tgl <= 1'b0;
         else if (m_edge) m_tgl <= !m_tgl;

         if (m_start || cs_fall || (!cfg.ctl_master && s_cs)) ecnt <= '0;
         else if (byte_done)                                   ecnt <= '0;
         else if (any_edge)                                    ecnt <= ecnt + 1'b1;

         if (tx_wr) txbuf <= tx_data;

         if (load)      sh <= txbuf;
         else if (shft) sh <= {sh[DATA_W-2:0], 1'b0};

         rxsh <= rx_next;
         if (byte_done) rxbuf <= rx_next;

         if (tx_wr)     tx_empty <= 1'b0;
         else if (load) tx_empty <= 1'b1;

         if (byte_done)  rx_full <= 1'b1;
         else if (rx_rd) rx_full <= 1'b0;
      end
   end

   always_comb begin
      status             = '0;
      status[ST_TXEMPTY] = tx_empty;
      status[ST_RXFULL]  = rx_full;
   end

   assign irq     = cfg.irq_on_rx ? rx_full : tx_empty;
   assign rx_data = rxbuf;
   assign sclk_o  = cfg.pol ^ m_tgl;
   assign sclk_oe = cfg.ctl_master;
   assign mosi_o  = sh[DATA_W-1];
   assign mosi_oe = cfg.ctl_master;
   assign miso_o  = sh[DATA_W-1];
   assign miso_oe = !cfg.ctl_master && !s_cs;
endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             master,
   input logic             cpol,
   input logic [DIV_W-1:0] div_val,
   input logic             tx_wr,
   input logic             rx_rd,
   input logic             st_txe,
   input logic             st_rxf,
   input logic             sclk_o,
   input logic             sclk_oe,
   input logic             mosi_oe,
   input logic             miso_oe,
   input logic             m_run,
   input logic             byte_done
);
   logic [DIV_W:0] hc;
   logic           sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc     <= '0;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= sclk_o;
         if (!m_run)                hc <= '0;
         else if (sclk_o != sclk_q) hc <= (DIV_W+1)'(1);
         else                       hc <= hc + 1'b1;
      end
   end

   a_r5_dir_master: assert property (@(posedge clk) disable iff (!rst_n)
      master |-> (sclk_oe && mosi_oe && !miso_oe));
   a_r5_dir_slave: assert property (@(posedge clk) disable iff (!rst_n)
      !master |-> (!sclk_oe && !mosi_oe));
   a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (master && !m_run) |-> (sclk_o == cpol));
   a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (m_run && $past(m_run) && (sclk_o != sclk_q)) |-> (hc == ({1'b0, div_val} + 1'b1)));
   a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr |=> !st_txe);
   a_r9_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> st_rxf);
   a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !byte_done) |=> !st_rxf);
endmodule

bind spi_byte_engine spi_byte_engine_chk #(.DIV_W(DIV_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .master(ctrl[0]), .cpol(ctrl[1]), .div_val(div_val),
   .tx_wr(tx_wr), .rx_rd(rx_rd), .st_txe(status[1]), .st_rxf(status[4]),
   .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
   .m_run(m_run), .byte_done(byte_done)
);

// File: tb/spi_byte_engine_tb_top.sv
`timescale 1ns/1ps
module spi_byte_engine_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_wr = 1'b0, rx_rd = 1'b0;
   logic [7:0] tx_data = '0, div_val = '0, ctrl = '0;
   logic [7:0] rx_data, status;
   logic irq, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
   logic sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, cs_n_i = 1'b1;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_byte_engine dut_i (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
      .rx_data(rx_data), .div_val(div_val), .ctrl(ctrl), .status(status), .irq(irq),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i), .mosi_o(mosi_o),
      .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe),
      .miso_i(miso_i), .cs_n_i(cs_n_i)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr_tx(input logic [7:0] b);
      tx_data = b; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic pulse_rd();
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk(status == 8'h02, "R9 reset status", status, 8'h02);
      chk(irq == 1'b1, "R10 reset irq from tx empty", irq, 1);
      chk({sclk_oe, mosi_oe, miso_oe} == 3'b000, "R5 peripheral idle enables", {sclk_oe, mosi_oe, miso_oe}, 0);
   endtask

   // controller word; bench acts as the far-end peripheral
   task automatic t_master(input logic cp, input logic ph, input logic [7:0] dv,
                           input logic [7:0] tb, input logic [7:0] sb, input bit rd_end);
      logic [7:0] got = '0;
      int j = 0, since = 0, bi = 7;
      logic prev;
      ctrl = {5'b0, ph, cp, 1'b1};
      div_val = dv;
      miso_i = sb[7];
      @(negedge clk);
      chk(sclk_o == cp, "R3 idle level before word", sclk_o, cp);
      chk({sclk_oe, mosi_oe, miso_oe} == 3'b110, "R5 controller enables", {sclk_oe, mosi_oe, miso_oe}, 3'b110);
      wr_tx(tb);
      chk(status[1] == 1'b0, "R6 write clears tx empty", status[1], 0);
      @(negedge clk);
      chk(status[1] == 1'b1, "R6 tx empty set on load", status[1], 1);
      chk(mosi_o == tb[7], "R4 first bit before first edge", mosi_o, tb[7]);
      prev = sclk_o;
      while (j < 16 && since < 4000) begin
         @(negedge clk);
         since++;
         if (sclk_o != prev) begin
            rx_rd = 1'b0;
            chk(since == int'(dv) + 1, "R2 half period", since, int'(dv) + 1);
            if (((j % 2) == 0) ^ ph) got = {got[6:0], mosi_o};
            else if (!(ph && j == 0)) begin
               bi--;
               if (bi >= 0) miso_i = sb[bi];
            end
            j++;
            since = 0;
            prev = sclk_o;
         end else if (rd_end && j == 15 && since == int'(dv)) begin
            rx_rd = 1'b1;
         end
      end
      rx_rd = 1'b0;
      chk(j == 16, "R1 sixteen clock edges", j, 16);
      chk(got == tb, "R1 R4 bits sent MSB first", got, tb);
      chk(rx_data == sb, "R1 R4 bits received MSB first", rx_data, sb);
      chk(status[4] == 1'b1, rd_end ? "R9 completion wins over same-cycle read" : "R9 rx full set",
          status[4], 1);
      chk(sclk_o == cp, "R3 idle level after word", sclk_o, cp);
   endtask

   task automatic t_irq();
      ctrl = 8'h41;
      @(negedge clk);
      chk(irq == 1'b1, "R10 irq follows rx full", irq, 1);
      pulse_rd();
      chk(status[4] == 1'b0, "R9 read clears rx full", status[4], 0);
      chk(irq == 1'b0, "R10 irq drops with rx full", irq, 0);
      ctrl = 8'h00;
      @(negedge clk);
      chk(irq == 1'b1, "R10 irq follows tx empty", irq, 1);
      wr_tx(8'h11);
      chk(irq == 1'b0, "R10 irq drops after tx write", irq, 0);
      chk(status == 8'h00, "R6 R9 status after write", status, 0);
   endtask

   // peripheral words; bench acts as the controller
   task automatic t_slave(input logic cp, input logic ph, input int h,
                          input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] m0, input logic [7:0] m1,
                          input bit two, input bit see_miso);
      ctrl = {5'b0, ph, cp, 1'b0};
      sclk_i = cp; cs_n_i = 1'b1; mosi_i = 1'b0;
      wr_tx(b0);
      repeat (6) @(negedge clk);
      chk({sclk_oe, mosi_oe, miso_oe} == 3'b000, "R5 peripheral deselected", {sclk_oe, mosi_oe, miso_oe}, 0);
      cs_n_i = 1'b0;
      repeat (5) @(negedge clk);
      chk(miso_oe == 1'b1, "R5 peripheral selected drives data", miso_oe, 1);
      if (two) wr_tx(b1);
      for (int k = 0; k < (two ? 2 : 1); k++) begin
         logic [7:0] m, b, got;
         m = (k == 0) ? m0 : m1;
         b = (k == 0) ? b0 : b1;
         got = '0;
         for (int i = 7; i >= 0; i--) begin
            if (!ph) begin
               mosi_i = m[i];
               repeat (h) @(negedge clk);
               got = {got[6:0], miso_o};
               sclk_i = ~cp;
               repeat (h) @(negedge clk);
               sclk_i = cp;
            end else begin
               sclk_i = ~cp;
               mosi_i = m[i];
               repeat (h) @(negedge clk);
               got = {got[6:0], miso_o};
               sclk_i = cp;
               repeat (h) @(negedge clk);
            end
         end
         repeat (5) @(negedge clk);
         chk(rx_data == m, (h <= 2) ? "R8 fast clock receive" : "R7 peripheral receive", rx_data, m);
         chk(status[4] == 1'b1, "R7 R9 word complete flag", status[4], 1);
         if (see_miso) chk(got == b, "R7 R1 peripheral transmit", got, b);
         pulse_rd();
      end
      cs_n_i = 1'b1;
      repeat (5) @(negedge clk);
      chk(miso_oe == 1'b0, "R5 data released on deselect", miso_oe, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_master(1'b0, 1'b0, 8'd5, 8'hA5, 8'h3C, 1'b0);
      t_master(1'b1, 1'b1, 8'd2, 8'h81, 8'h7E, 1'b0);
      t_master(1'b0, 1'b1, 8'd0, 8'h5A, 8'hC3, 1'b0);
      t_master(1'b1, 1'b0, 8'd3, 8'h96, 8'h69, 1'b1);
      t_irq();
      t_slave(1'b0, 1'b0, 6, 8'hC5, 8'h3A, 8'h9B, 8'h64, 1'b1, 1'b1);
      t_slave(1'b1, 1'b1, 6, 8'h0F, 8'hF1, 8'hE2, 8'h1D, 1'b1, 1'b1);
      t_slave(1'b1, 1'b0, 2, 8'h55, 8'h00, 8'hB7, 8'h00, 1'b0, 1'b0);
      finish_run();
   end
endmodule